// File: doc/BRIEF.md
# Latched Event Interrupt Controller with Read-to-Clear

This block gathers twelve event sources from a two-wire serial bus controller and turns them into one interrupt line. Ten of the sources are short pulses that set a sticky status bit; the remaining two (transmit queue low and receive queue high) are levels that the status view shows directly. A mask register selects which status bits may raise the interrupt. Software clears a sticky bit by reading that bit's own clear address, or clears every sticky bit at once by reading a combined clear address. When a transmit-abort pulse arrives, the block also gathers the abort reason bits into an abort-source register.

The block also holds the controller's enable command together with an enable-status flag that follows it. Turning on takes one cycle. Turning off waits until the bus has been idle for a set number of back-to-back cycles. Event pulses set status bits only while the enable status is high. Software reaches everything through a simple register port: a select strobe, a write strobe, an address, and data in and out. Read data is combinational in the same cycle as the read strobe. A clear caused by a read takes effect at the clock edge that ends the read cycle.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: While enabled, a pulse on any event input except bits 4 and 2 sets its sticky bit at the next edge. The raw status read at address 0 uses these bit positions: general call 11, start 10, stop 9, activity 8, receive done 7, transmit abort 6, read request 5, transmit low 4, transmit overflow 3, receive high 2, receive overflow 1, receive underflow 0.
- R2: Status bit 4 follows tx_below_i and bit 2 follows rx_above_i without delay. Neither bit is latched, and no clear read affects either one.
- R3: The mask register at address 1 reads back what was written. Address 2 returns status AND mask. irq_o is high exactly when status AND mask is nonzero.
- R4: Each sticky bit has a read-to-clear address, numbered 4 to 13 in this order of bits: 0, 1, 3, 5, 6, 7, 8, 9, 10, 11. A read returns the bit's value before the clear in data bit 0. A write to any of these addresses changes nothing.
- R5: A read of address 3 returns every sticky bit and clears all of them.
- R6: An event pulse that arrives in the same cycle as a clear of its bit leaves the bit set.
- R7: Address 16 holds the abort-source bits. On each transmit-abort pulse, abrt_reason_i is ORed into them. A read of address 8 clears them together with the transmit-abort bit.
- R8: Address 14 holds the enable command in bit 0. Address 15 bit 0 and en_state_o go high one cycle after the command edge that turns the block on.
- R9: After the command turns the block off, en_state_o stays high until bus_idle_i has been high for IDLE_CYCLES back-to-back cycles. Any cycle that is not idle restarts the count.
- R10: While en_state_o is low, event pulses set no sticky bit and add nothing to the abort source.
- R11: After reset, the mask, sticky bits, abort source, enable command and enable status are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of a read |
| evt_i | input | 12 | Event pulses, one per status bit |
| tx_below_i | input | 1 | Level: transmit queue at or below threshold |
| rx_above_i | input | 1 | Level: receive queue above threshold |
| abrt_reason_i | input | ABRT_W | Abort reason bits, sampled on an abort pulse |
| bus_idle_i | input | 1 | Serial bus is idle |
| irq_o | output | 1 | Interrupt request |
| en_state_o | output | 1 | Actual enable state |

## Verification
The bench changes inputs just after a rising edge and samples at the following falling edge. Read data and irq_o are combinational, so the bench checks a read's returned value in the same half cycle, before any clear it causes has happened. Sticky bits, clears and the mask change at the edge that ends the cycle, so each effect is checked by a read in the cycle after that edge. Level bits and irq_o are checked in the half cycle right after the level changes. The enable status is checked at the exact edge count from R8 and R9: it is still low one cycle after the command, high after the second edge, still high after IDLE_CYCLES-1 idle edges, and low after the last one.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int NUM_SRC = 12;
    localparam int ADDR_W  = 5;

    // status bit positions
    localparam int B_RXUF = 0;
    localparam int B_RXOF = 1;
    localparam int B_RXHI = 2;
    localparam int B_TXOF = 3;
    localparam int B_TXLO = 4;
    localparam int B_RREQ = 5;
    localparam int B_TABT = 6;
    localparam int B_RXDN = 7;
    localparam int B_ACTV = 8;
    localparam int B_STOP = 9;
    localparam int B_STRT = 10;
    localparam int B_GCAL = 11;

    localparam logic [NUM_SRC-1:0] LEVEL_MASK = NUM_SRC'((1 << B_TXLO) | (1 << B_RXHI));
    localparam logic [NUM_SRC-1:0] LATCH_MASK = ~LEVEL_MASK;

    // register addresses
    localparam logic [ADDR_W-1:0] A_RAW    = 5'd0;
    localparam logic [ADDR_W-1:0] A_MASK   = 5'd1;
    localparam logic [ADDR_W-1:0] A_MSTAT  = 5'd2;
    localparam logic [ADDR_W-1:0] A_CLRALL = 5'd3;
    localparam logic [ADDR_W-1:0] A_ENCMD  = 5'd14;
    localparam logic [ADDR_W-1:0] A_ENST   = 5'd15;
    localparam logic [ADDR_W-1:0] A_ABRT   = 5'd16;

    // per-source read-to-clear decode
    function automatic logic [NUM_SRC-1:0] clr_sel(input logic [ADDR_W-1:0] a);
        logic [NUM_SRC-1:0] s;
        s = '0;
        case (a)
            5'd4:  s[B_RXUF] = 1'b1;
            5'd5:  s[B_RXOF] = 1'b1;
            5'd6:  s[B_TXOF] = 1'b1;
            5'd7:  s[B_RREQ] = 1'b1;
            5'd8:  s[B_TABT] = 1'b1;
            5'd9:  s[B_RXDN] = 1'b1;
            5'd10: s[B_ACTV] = 1'b1;
            5'd11: s[B_STOP] = 1'b1;
            5'd12: s[B_STRT] = 1'b1;
            5'd13: s[B_GCAL] = 1'b1;
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch
    import i2c_irq_pkg::*;
#(
    parameter int                 N      = NUM_SRC,
    parameter logic [N-1:0]       STICKY = LATCH_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] clr,
    output logic [N-1:0] latched,
    output logic [N-1:0] status
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (STICKY[i]) begin : g_sticky
            logic bit_d, bit_q;

            always_comb begin
                bit_d = bit_q;
                if (clr[i]) begin
                    bit_d = 1'b0;
                end
                if (en && evt[i]) begin
                    bit_d = 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else begin
                    bit_q <= bit_d;
                end
            end

            assign latched[i] = bit_q;
            assign status[i]  = bit_q;
        end else begin : g_level
            assign latched[i] = 1'b0;
            assign status[i]  = lvl[i];
        end
    end

endmodule

// File: rtl/irq_abort_src.sv
module irq_abort_src #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         abort_evt,
    input  logic [W-1:0] reason,
    input  logic         clr,
    output logic [W-1:0] src
);

    typedef struct packed {
        logic [W-1:0] bits;
    } abrt_t;

    abrt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.bits = '0;
        end
        if (en && abort_evt) begin
            st_d.bits = st_d.bits | reason;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src = st_q.bits;

endmodule

// File: rtl/irq_enable_sync.sv
module irq_enable_sync #(
    parameter int IDLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic cmd_val,
    input  logic bus_idle,
    output logic cmd,
    output logic state
);

    localparam int CW = (IDLE_CYCLES > 1) ? $clog2(IDLE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

    typedef struct packed {
        logic          cmd;
        logic          state;
        logic [CW-1:0] cnt;
    } en_t;

    en_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_wr) begin
            st_d.cmd = cmd_val;
        end
        if (st_q.cmd && !st_q.state) begin
            st_d.state = 1'b1;
            st_d.cnt   = '0;
        end else if (!st_q.cmd && st_q.state) begin
            if (!bus_idle) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == LAST) begin
                st_d.state = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd   = st_q.cmd;
    assign state = st_q.state;

endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
    import i2c_irq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ABRT_W      = 16,
    parameter int IDLE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic              tx_below_i,
    input  logic              rx_above_i,
    input  logic [ABRT_W-1:0] abrt_reason_i,
    input  logic              bus_idle_i,
    output logic              irq_o,
    output logic              en_state_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
    } regs_t;

    regs_t r_d, r_q;

    logic               rd_stb, wr_stb;
    logic [NUM_SRC-1:0] lvl_vec, clr_vec, status, latched_q, mask_q;
    logic [ABRT_W-1:0]  abrt_q;
    logic               en_cmd, en_state;

    assign rd_stb = bus_sel && !bus_wr;
    assign wr_stb = bus_sel && bus_wr;

    always_comb begin
        lvl_vec         = '0;
        lvl_vec[B_TXLO] = tx_below_i;
        lvl_vec[B_RXHI] = rx_above_i;
    end

    always_comb begin
        clr_vec = '0;
        if (rd_stb) begin
            clr_vec = clr_sel(bus_addr);
            if (bus_addr == A_CLRALL) begin
                clr_vec = '1;
            end
        end
    end

    irq_src_latch #(
        .N      (NUM_SRC),
        .STICKY (LATCH_MASK)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_state),
        .evt     (evt_i),
        .lvl     (lvl_vec),
        .clr     (clr_vec),
        .latched (latched_q),
        .status  (status)
    );

    irq_abort_src #(
        .W (ABRT_W)
    ) u_abrt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_state),
        .abort_evt (evt_i[B_TABT]),
        .reason    (abrt_reason_i),
        .clr       (clr_vec[B_TABT] && !(bus_addr == A_CLRALL)),
        .src       (abrt_q)
    );

    irq_enable_sync #(
        .IDLE_CYCLES (IDLE_CYCLES)
    ) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (wr_stb && (bus_addr == A_ENCMD)),
        .cmd_val  (bus_wdata[0]),
        .bus_idle (bus_idle_i),
        .cmd      (en_cmd),
        .state    (en_state)
    );

    always_comb begin
        r_d = r_q;
        if (wr_stb && (bus_addr == A_MASK)) begin
            r_d.mask = bus_wdata[NUM_SRC-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mask_q = r_q.mask;

    always_comb begin
        bus_rdata = '0;
        if (rd_stb) begin
            case (bus_addr)
                A_RAW:    bus_rdata = DATA_W'(status);
                A_MASK:   bus_rdata = DATA_W'(mask_q);
                A_MSTAT:  bus_rdata = DATA_W'(status & mask_q);
                A_CLRALL: bus_rdata = DATA_W'(latched_q);
                A_ENCMD:  bus_rdata = DATA_W'(en_cmd);
                A_ENST:   bus_rdata = DATA_W'(en_state);
                A_ABRT:   bus_rdata = DATA_W'(abrt_q);
                default:  bus_rdata = DATA_W'(|(latched_q & clr_sel(bus_addr)));
            endcase
        end
    end

    assign irq_o      = |(status & mask_q);
    assign en_state_o = en_state;

endmodule

// File: rtl/i2c_irq_ctrl_chk.sv
module i2c_irq_ctrl_chk
    import i2c_irq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               bus_idle_i,
    input logic               irq_o,
    input logic               en_state_o,
    input logic [NUM_SRC-1:0] latched_q,
    input logic [NUM_SRC-1:0] mask_q
);

    assert_latch_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_state_o && |(evt_i & LATCH_MASK))
        |=> ((latched_q & $past(evt_i & LATCH_MASK)) == $past(evt_i & LATCH_MASK)));

    assert_irq_needs_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mask_q != '0));

    assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == A_CLRALL)
        |=> ((latched_q & ~$past(evt_i)) == '0));

    assert_enable_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_ENCMD && bus_wdata[0] && !en_state_o)
        |=> ##1 en_state_o);

    assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_state_o) |-> $past(bus_idle_i));

    assert_no_set_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(latched_q & ~$past(latched_q))) |-> $past(en_state_o));

endmodule

bind i2c_irq_ctrl i2c_irq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .evt_i      (evt_i),
    .bus_idle_i (bus_idle_i),
    .irq_o      (irq_o),
    .en_state_o (en_state_o),
    .latched_q  (latched_q),
    .mask_q     (mask_q)
);

// File: tb/i2c_irq_ctrl_test.sv
`timescale 1ns/1ps
module i2c_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [11:0] evt_i = '0;
    logic        tx_below_i = 1'b0, rx_above_i = 1'b0;
    logic [15:0] abrt_reason_i = '0;
    logic        bus_idle_i = 1'b1;
    logic        irq_o, en_state_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    i2c_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_i(evt_i), .tx_below_i(tx_below_i), .rx_above_i(rx_above_i),
        .abrt_reason_i(abrt_reason_i), .bus_idle_i(bus_idle_i),
        .irq_o(irq_o), .en_state_o(en_state_o)
    );

    // {kind(0 idle,1 write,2 read), addr, wdata, evt, exp_rdata, exp_irq}
    localparam int NV = 16;
    localparam logic [51:0] VEC [NV] = '{
        {2'd1, 5'd1,  16'h0FFF, 12'h000, 16'h0000, 1'b0}, // R3 mask all
        {2'd0, 5'd0,  16'h0000, 12'h001, 16'h0000, 1'b0}, // R1 rx underflow
        {2'd2, 5'd0,  16'h0000, 12'h000, 16'h0001, 1'b1}, // R1 raw
        {2'd2, 5'd2,  16'h0000, 12'h000, 16'h0001, 1'b1}, // R3 masked
        {2'd0, 5'd0,  16'h0000, 12'hE20, 16'h0000, 1'b0}, // R1 several
        {2'd2, 5'd0,  16'h0000, 12'h000, 16'h0E21, 1'b1}, // R1 raw
        {2'd2, 5'd7,  16'h0000, 12'h000, 16'h0001, 1'b1}, // R4 clear rdreq
        {2'd2, 5'd0,  16'h0000, 12'h000, 16'h0E01, 1'b1}, // R4 after clear
        {2'd1, 5'd11, 16'hFFFF, 12'h000, 16'h0000, 1'b0}, // R4 write no effect
        {2'd2, 5'd0,  16'h0000, 12'h000, 16'h0E01, 1'b1}, // R4 unchanged
        {2'd2, 5'd3,  16'h0000, 12'h000, 16'h0E01, 1'b1}, // R5 clear all
        {2'd2, 5'd0,  16'h0000, 12'h000, 16'h0000, 1'b0}, // R5 empty
        {2'd2, 5'd4,  16'h0000, 12'h000, 16'h0000, 1'b0}, // R4 cleared bit
        {2'd1, 5'd1,  16'h0002, 12'h008, 16'h0000, 1'b0}, // R3 new mask
        {2'd2, 5'd2,  16'h0000, 12'h000, 16'h0000, 1'b0}, // R3 masked out
        {2'd2, 5'd0,  16'h0000, 12'h000, 16'h0008, 1'b0}  // R1 tx overflow
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic nxt();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_bus();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        nxt();
        idle_bus();
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string req);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        chk(32'(bus_rdata), 32'(exp), req);
        nxt();
        idle_bus();
    endtask

    task automatic pulse(input logic [11:0] e, input logic [15:0] why);
        evt_i = e; abrt_reason_i = why;
        nxt();
        evt_i = '0; abrt_reason_i = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(32'(irq_o), 0, "R11 irq");
        chk(32'(en_state_o), 0, "R11 en_state");
        nxt();
        rd(5'd0, 16'h0000, "R11 raw");
        rd(5'd1, 16'h0000, "R11 mask");
        rd(5'd15, 16'h0000, "R11 enable status");
        rd(5'd16, 16'h0000, "R11 abort source");

        // R10 events ignored while disabled
        pulse(12'hFFF, 16'hFFFF);
        rd(5'd0, 16'h0000, "R10 raw while off");
        rd(5'd16, 16'h0000, "R10 abort while off");

        // R8 enable handshake
        wr(5'd14, 16'h0001);
        @(negedge clk);
        chk(32'(en_state_o), 0, "R8 one cycle after command");
        nxt();
        @(negedge clk);
        chk(32'(en_state_o), 1, "R8 enabled");
        nxt();
        rd(5'd15, 16'h0001, "R8 status reg");
        rd(5'd14, 16'h0001, "R8 command reg");

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [51:0] v;
            v = VEC[i];
            bus_sel   = (v[51:50] != 2'd0);
            bus_wr    = (v[51:50] == 2'd1);
            bus_addr  = v[49:45];
            bus_wdata = v[44:29];
            evt_i     = v[28:17];
            @(negedge clk);
            if (v[51:50] == 2'd2) begin
                chk(32'(bus_rdata), 32'(v[16:1]), $sformatf("R1/R3/R4/R5 row %0d rdata", i));
                chk(32'(irq_o), 32'(v[0]), $sformatf("R3 row %0d irq", i));
            end
            nxt();
            idle_bus();
            evt_i = '0;
        end

        // R2 level bits
        wr(5'd1, 16'h0010);
        tx_below_i = 1'b1; rx_above_i = 1'b1;
        @(negedge clk);
        chk(32'(irq_o), 1, "R2 level irq");
        nxt();
        rd(5'd3, 16'h0008, "R5 clear all excludes levels");
        rd(5'd0, 16'h0014, "R2 levels after clear all");
        rd(5'd5, 16'h0000, "R4 clear rx overflow");
        rd(5'd0, 16'h0014, "R2 levels stay");
        tx_below_i = 1'b0; rx_above_i = 1'b0;
        @(negedge clk);
        chk(32'(irq_o), 0, "R2 level drop irq");
        nxt();
        rd(5'd0, 16'h0000, "R2 raw after drop");

        // R6 set wins over clear
        evt_i = 12'h001;
        rd(5'd4, 16'h0000, "R6 clear read value");
        evt_i = '0;
        rd(5'd0, 16'h0001, "R6 bit kept");

        // R7 abort source
        pulse(12'h000, 16'h0100);
        pulse(12'h040, 16'h0005);
        pulse(12'h040, 16'h0010);
        rd(5'd16, 16'h0015, "R7 accumulated");
        rd(5'd8, 16'h0001, "R7 abort clear read");
        rd(5'd16, 16'h0000, "R7 source cleared");
        rd(5'd0, 16'h0001, "R7 abort bit cleared");

        // R9 disable waits for idle
        bus_idle_i = 1'b0;
        wr(5'd14, 16'h0000);
        repeat (6) nxt();
        @(negedge clk);
        chk(32'(en_state_o), 1, "R9 held while busy");
        nxt();
        bus_idle_i = 1'b1;
        repeat (3) nxt();
        @(negedge clk);
        chk(32'(en_state_o), 1, "R9 before last idle cycle");
        nxt();
        @(negedge clk);
        chk(32'(en_state_o), 0, "R9 disabled");
        nxt();
        rd(5'd15, 16'h0000, "R9 status reg");
        rd(5'd14, 16'h0000, "R8 command reg off");

        // R10 again after disable
        pulse(12'h002, 16'h0000);
        rd(5'd0, 16'h0001, "R10 raw after disable");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule